// File: doc/BRIEF.md
# Progressive Up-the-Ramp Slope Fitter

The block estimates the photocurrent of every spaxel of a detector read out non-destructively. Each spaxel's signal climbs through a series of frames until a destructive reset ends the ramp. Samples arrive one per cycle on a shared stream, and each sample is tagged with its spaxel index and with markers for ramp start and ramp end. The block can add consecutive frames into groups of a programmable size. It can drop a programmable number of early groups. The accepted groups are folded into five running sums per spaxel: count, sum of group index, sum of group value, sum of index times value, and sum of squared index. No sample history is kept.

When a ramp closes, the block emits the integer numerator and denominator of the least-squares slope, together with the number of accepted groups and a flag for a fit that cannot be formed. A ramp closes on its end marker or when the programmed ramp length in groups is reached. Division into physical units happens downstream. The stream runs at full rate, so samples of different spaxels may be interleaved freely.

Top module: `ramp_slope_fitter`

## Requirements
- R1: After reset every spaxel is idle and out_valid is low; a sample for an idle spaxel without in_first set is ignored and produces no output, even if in_last is set.
- R2: A sample with in_first set clears that spaxel's running state and counts as the first frame of a new ramp, even when an earlier ramp of that spaxel is still open.
- R3: Consecutive frames of a spaxel are added into groups of cfg_group_frames frames (1 to MAX_FRAMES); the group value is the plain sum of its frames.
- R4: The first cfg_skip_groups completed groups of a ramp are discarded; the first accepted group has index t = 0 and each later group raises t by one.
- R5: With n accepted groups of index t and value y, out_num = n·Σty − Σt·Σy (two's complement) and out_den = n·Σt² − (Σt)², and out_count = n.
- R6: A sample with in_last set closes an open ramp; frames of an incomplete final group are dropped; out_pix carries the spaxel index.
- R7: A ramp also closes when its completed group count, skipped groups included, reaches cfg_max_groups; later samples of that spaxel are ignored until the next in_first.
- R8: When n < 2 the result has out_den = 0 and out_invalid = 1; otherwise out_invalid = 0 and out_den > 0.
- R9: The running state of each spaxel is independent of the others under interleaved samples.
- R10: MAX_GROUPS groups of MAX_FRAMES full-scale frames fold into the sums without wrap-around.
- R11: One sample is taken per cycle; out_valid is high for exactly the one cycle after a closing sample and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_group_frames | input | FRM_W | Frames added into one group |
| cfg_skip_groups | input | CNT_W | Early groups discarded per ramp |
| cfg_max_groups | input | CNT_W | Ramp length in groups |
| in_valid | input | 1 | Sample present this cycle |
| in_pix | input | PIX_W | Spaxel index of the sample |
| in_sample | input | SAMPLE_W | Unsigned sample value |
| in_first | input | 1 | Sample opens a new ramp |
| in_last | input | 1 | Sample is the last before destructive reset |
| out_valid | output | 1 | Result present this cycle |
| out_pix | output | PIX_W | Spaxel of the result |
| out_num | output | NUM_W | Signed slope numerator |
| out_den | output | DEN_W | Slope denominator |
| out_count | output | CNT_W | Accepted group count |
| out_invalid | output | 1 | Fewer than two accepted groups |

## Verification
The assertions assume that the three configuration inputs stay constant while any ramp is open. They also assume that cfg_group_frames lies between 1 and MAX_FRAMES and that cfg_max_groups lies between 1 and MAX_GROUPS. The frame-bound and accepted-count properties rely on these limits. The bench changes configuration only between scenarios, after every open ramp has been closed or restarted. It sets every configuration value inside those limits. Its full-scale scenario drives the largest group size and ramp length, which is the worst case for the wrap-around property.

// File: rtl/ramp_fit_pkg.sv
package ramp_fit_pkg;
  // What a sample does to the group stage of its spaxel
  typedef enum logic [1:0] {
    GRP_PEND = 2'd0,  // group still filling
    GRP_SKIP = 2'd1,  // group completed, discarded
    GRP_TAKE = 2'd2   // group completed, folded into the sums
  } grp_act_e;
endpackage

// File: rtl/ramp_sum_bank.sv
module ramp_sum_bank
  import ramp_fit_pkg::*;
#(
  parameter int NUM_PIX = 8,
  parameter int PIX_W   = 3,
  parameter int SAMPLE_W = 12,
  parameter int FRM_W   = 3,
  parameter int CNT_W   = 6,
  parameter int GSUM_W  = 15,
  parameter int ST_W    = 12,
  parameter int SY_W    = 21,
  parameter int STY_W   = 27,
  parameter int STT_W   = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FRM_W-1:0]    cfg_group_frames,
  input  logic [CNT_W-1:0]    cfg_skip_groups,
  input  logic [CNT_W-1:0]    cfg_max_groups,
  input  logic                in_valid,
  input  logic [PIX_W-1:0]    in_pix,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_first,
  input  logic                in_last,
  output logic                upd_close,
  output logic [CNT_W-1:0]    upd_n,
  output logic [ST_W-1:0]     upd_st,
  output logic [SY_W-1:0]     upd_sy,
  output logic [STY_W-1:0]    upd_sty,
  output logic [STT_W-1:0]    upd_stt
);
  logic              act_q  [NUM_PIX];
  logic [FRM_W-1:0]  fr_q   [NUM_PIX];
  logic [GSUM_W-1:0] part_q [NUM_PIX];
  logic [CNT_W-1:0]  g_q    [NUM_PIX];
  logic [CNT_W-1:0]  n_q    [NUM_PIX];
  logic [ST_W-1:0]   st_q   [NUM_PIX];
  logic [SY_W-1:0]   sy_q   [NUM_PIX];
  logic [STY_W-1:0]  sty_q  [NUM_PIX];
  logic [STT_W-1:0]  stt_q  [NUM_PIX];

  logic              b_act;
  logic [FRM_W-1:0]  b_fr, fr_inc, fr_nxt;
  logic [GSUM_W-1:0] b_part, part_sum, part_nxt;
  logic [CNT_W-1:0]  b_g, g_nxt, b_n, n_nxt, t_idx;
  logic [ST_W-1:0]   b_st, st_nxt;
  logic [SY_W-1:0]   b_sy, sy_nxt;
  logic [STY_W-1:0]  b_sty, sty_nxt;
  logic [STT_W-1:0]  b_stt, stt_nxt;
  logic              grp_done, hit_max, live, close;
  grp_act_e          grp_act;

  // Base state: a ramp start behaves as a cleared, open spaxel
  always_comb begin
    if (in_first) begin
      b_act = 1'b1;  b_fr = '0;  b_part = '0;  b_g = '0;  b_n = '0;
      b_st = '0;     b_sy = '0;  b_sty = '0;   b_stt = '0;
    end else begin
      b_act = act_q[in_pix];  b_fr = fr_q[in_pix];  b_part = part_q[in_pix];
      b_g = g_q[in_pix];      b_n = n_q[in_pix];    b_st = st_q[in_pix];
      b_sy = sy_q[in_pix];    b_sty = sty_q[in_pix]; b_stt = stt_q[in_pix];
    end
  end

  // Group stage and progressive sums
  always_comb begin
    part_sum = b_part + GSUM_W'(in_sample);
    fr_inc   = b_fr + FRM_W'(1);
    grp_done = (fr_inc == cfg_group_frames);
    t_idx    = b_g - cfg_skip_groups;
    if (!grp_done)                    grp_act = GRP_PEND;
    else if (b_g >= cfg_skip_groups)  grp_act = GRP_TAKE;
    else                              grp_act = GRP_SKIP;
    g_nxt    = grp_done ? b_g + CNT_W'(1) : b_g;
    fr_nxt   = grp_done ? '0 : fr_inc;
    part_nxt = grp_done ? '0 : part_sum;
    n_nxt = b_n;  st_nxt = b_st;  sy_nxt = b_sy;  sty_nxt = b_sty;  stt_nxt = b_stt;
    if (grp_act == GRP_TAKE) begin
      n_nxt   = b_n + CNT_W'(1);
      st_nxt  = b_st + ST_W'(t_idx);
      sy_nxt  = b_sy + SY_W'(part_sum);
      sty_nxt = b_sty + STY_W'(t_idx) * STY_W'(part_sum);
      stt_nxt = b_stt + STT_W'(t_idx) * STT_W'(t_idx);
    end
    hit_max = grp_done && (g_nxt == cfg_max_groups);
    live    = in_valid && b_act;
    close   = live && (in_last || hit_max);
  end

  assign upd_close = close;
  assign upd_n     = n_nxt;
  assign upd_st    = st_nxt;
  assign upd_sy    = sy_nxt;
  assign upd_sty   = sty_nxt;
  assign upd_stt   = stt_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PIX; i++) begin
        act_q[i] <= 1'b0;  fr_q[i] <= '0;  part_q[i] <= '0;  g_q[i] <= '0;
        n_q[i] <= '0;      st_q[i] <= '0;  sy_q[i] <= '0;    sty_q[i] <= '0;
        stt_q[i] <= '0;
      end
    end else if (live) begin
      act_q[in_pix]  <= !close;
      fr_q[in_pix]   <= fr_nxt;
      part_q[in_pix] <= part_nxt;
      g_q[in_pix]    <= g_nxt;
      n_q[in_pix]    <= n_nxt;
      st_q[in_pix]   <= st_nxt;
      sy_q[in_pix]   <= sy_nxt;
      sty_q[in_pix]  <= sty_nxt;
      stt_q[in_pix]  <= stt_nxt;
    end
  end

  // R10: folding a group never wraps a running sum
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && grp_act == GRP_TAKE) |->
      (sty_nxt >= b_sty && stt_nxt >= b_stt && sy_nxt >= b_sy && st_nxt >= b_st));

  // R3: a partly filled group never holds a full group's frames
  assert_frame_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (b_fr < cfg_group_frames));

  // R4: accepted groups never outnumber completed groups
  assert_accept_le_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (n_nxt <= g_nxt));
endmodule

// File: rtl/ramp_fit_result.sv
module ramp_fit_result #(
  parameter int PIX_W = 3,
  parameter int CNT_W = 6,
  parameter int ST_W  = 12,
  parameter int SY_W  = 21,
  parameter int STY_W = 27,
  parameter int STT_W = 18,
  parameter int NUM_W = 34,
  parameter int DEN_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_close,
  input  logic [PIX_W-1:0]        upd_pix,
  input  logic [CNT_W-1:0]        upd_n,
  input  logic [ST_W-1:0]         upd_st,
  input  logic [SY_W-1:0]         upd_sy,
  input  logic [STY_W-1:0]        upd_sty,
  input  logic [STT_W-1:0]        upd_stt,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pix,
  output logic signed [NUM_W-1:0] out_num,
  output logic [DEN_W-1:0]        out_den,
  output logic [CNT_W-1:0]        out_count,
  output logic                    out_invalid
);
  logic [NUM_W-1:0] num_d;
  logic [DEN_W-1:0] den_d;
  logic             inv_d;

  // Two's complement difference is exact because the true value fits NUM_W
  always_comb begin
    num_d = NUM_W'(upd_n) * NUM_W'(upd_sty) - NUM_W'(upd_st) * NUM_W'(upd_sy);
    den_d = DEN_W'(upd_n) * DEN_W'(upd_stt) - DEN_W'(upd_st) * DEN_W'(upd_st);
    inv_d = (upd_n < CNT_W'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= upd_close;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix <= '0;  out_num <= '0;  out_den <= '0;  out_count <= '0;  out_invalid <= 1'b0;
    end else if (upd_close) begin
      out_pix     <= upd_pix;
      out_num     <= num_d;
      out_den     <= den_d;
      out_count   <= upd_n;
      out_invalid <= inv_d;
    end
  end

  // R8: a degenerate fit carries a zero denominator
  assert_invalid_zero_den_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_den == '0));

  // R8: two or more distinct indices give a strictly positive denominator
  assert_valid_pos_den_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_invalid) |-> (out_den != '0));
endmodule

// File: rtl/ramp_slope_fitter.sv
module ramp_slope_fitter #(
  parameter int NUM_PIX    = 8,
  parameter int SAMPLE_W   = 12,
  parameter int MAX_FRAMES = 4,
  parameter int MAX_GROUPS = 32,
  localparam int PIX_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1,
  localparam int FRM_W  = $clog2(MAX_FRAMES + 1),
  localparam int CNT_W  = $clog2(MAX_GROUPS + 1),
  localparam int GSUM_W = SAMPLE_W + FRM_W,
  localparam int ST_W   = 2 * CNT_W,
  localparam int SY_W   = GSUM_W + CNT_W,
  localparam int STY_W  = GSUM_W + 2 * CNT_W,
  localparam int STT_W  = 3 * CNT_W,
  localparam int NUM_W  = STY_W + CNT_W + 1,
  localparam int DEN_W  = STT_W + CNT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FRM_W-1:0]        cfg_group_frames,
  input  logic [CNT_W-1:0]        cfg_skip_groups,
  input  logic [CNT_W-1:0]        cfg_max_groups,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        in_pix,
  input  logic [SAMPLE_W-1:0]     in_sample,
  input  logic                    in_first,
  input  logic                    in_last,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pix,
  output logic signed [NUM_W-1:0] out_num,
  output logic [DEN_W-1:0]        out_den,
  output logic [CNT_W-1:0]        out_count,
  output logic                    out_invalid
);
  logic             upd_close;
  logic [CNT_W-1:0] upd_n;
  logic [ST_W-1:0]  upd_st;
  logic [SY_W-1:0]  upd_sy;
  logic [STY_W-1:0] upd_sty;
  logic [STT_W-1:0] upd_stt;

  ramp_sum_bank #(
    .NUM_PIX(NUM_PIX), .PIX_W(PIX_W), .SAMPLE_W(SAMPLE_W), .FRM_W(FRM_W),
    .CNT_W(CNT_W), .GSUM_W(GSUM_W), .ST_W(ST_W), .SY_W(SY_W),
    .STY_W(STY_W), .STT_W(STT_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_group_frames(cfg_group_frames), .cfg_skip_groups(cfg_skip_groups),
    .cfg_max_groups(cfg_max_groups),
    .in_valid(in_valid), .in_pix(in_pix), .in_sample(in_sample),
    .in_first(in_first), .in_last(in_last),
    .upd_close(upd_close), .upd_n(upd_n), .upd_st(upd_st), .upd_sy(upd_sy),
    .upd_sty(upd_sty), .upd_stt(upd_stt)
  );

  ramp_fit_result #(
    .PIX_W(PIX_W), .CNT_W(CNT_W), .ST_W(ST_W), .SY_W(SY_W), .STY_W(STY_W),
    .STT_W(STT_W), .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) u_result (
    .clk(clk), .rst_n(rst_n),
    .upd_close(upd_close), .upd_pix(in_pix), .upd_n(upd_n), .upd_st(upd_st),
    .upd_sy(upd_sy), .upd_sty(upd_sty), .upd_stt(upd_stt),
    .out_valid(out_valid), .out_pix(out_pix), .out_num(out_num),
    .out_den(out_den), .out_count(out_count), .out_invalid(out_invalid)
  );

  // R11: a cycle with no input sample is never followed by a result
  assert_no_spurious_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7: a reported ramp never holds more accepted groups than its length
  assert_count_le_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count <= cfg_max_groups));
endmodule

// File: tb/tb_ramp_slope_fitter.sv
module tb_ramp_slope_fitter;
  localparam int NPIX = 8;
  localparam int SW = 12;
  localparam int MF = 4;
  localparam int MG = 32;
  localparam int PW = $clog2(NPIX);
  localparam int FW = $clog2(MF + 1);
  localparam int CW = $clog2(MG + 1);
  localparam int NW = (SW + FW + 2 * CW) + CW + 1;
  localparam int DW = 3 * CW + CW;

  logic clk, rst_n;
  logic [FW-1:0] cfg_group_frames;
  logic [CW-1:0] cfg_skip_groups, cfg_max_groups;
  logic in_valid, in_first, in_last;
  logic [PW-1:0] in_pix;
  logic [SW-1:0] in_sample;
  logic out_valid, out_invalid;
  logic [PW-1:0] out_pix;
  logic signed [NW-1:0] out_num;
  logic [DW-1:0] out_den;
  logic [CW-1:0] out_count;

  ramp_slope_fitter #(.NUM_PIX(NPIX), .SAMPLE_W(SW), .MAX_FRAMES(MF), .MAX_GROUPS(MG)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_group_frames(cfg_group_frames),
    .cfg_skip_groups(cfg_skip_groups), .cfg_max_groups(cfg_max_groups),
    .in_valid(in_valid), .in_pix(in_pix), .in_sample(in_sample),
    .in_first(in_first), .in_last(in_last), .out_valid(out_valid), .out_pix(out_pix),
    .out_num(out_num), .out_den(out_den), .out_count(out_count), .out_invalid(out_invalid));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Reference state per spaxel, built from the requirements
  bit     m_act [NPIX];
  int     m_fr [NPIX], m_g [NPIX];
  longint m_part [NPIX], m_n [NPIX], m_st [NPIX], m_sy [NPIX], m_sty [NPIX], m_stt [NPIX];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one sample, advance the model, check the cycle after the edge
  task automatic feed(input int p, input int v, input bit first, input bit last, input string tag);
    bit close;
    longint en, eden;
    in_valid = 1'b1; in_pix = PW'(p); in_sample = SW'(v); in_first = first; in_last = last;
    close = 1'b0;
    if (first) begin
      m_act[p] = 1'b1; m_fr[p] = 0; m_g[p] = 0; m_part[p] = 0;
      m_n[p] = 0; m_st[p] = 0; m_sy[p] = 0; m_sty[p] = 0; m_stt[p] = 0;
    end
    if (m_act[p]) begin
      m_part[p] += v; m_fr[p]++;
      if (m_fr[p] == int'(cfg_group_frames)) begin
        if (m_g[p] >= int'(cfg_skip_groups)) begin
          longint t = m_g[p] - int'(cfg_skip_groups);
          m_n[p]++; m_st[p] += t; m_sy[p] += m_part[p];
          m_sty[p] += t * m_part[p]; m_stt[p] += t * t;
        end
        m_g[p]++; m_fr[p] = 0; m_part[p] = 0;
        if (m_g[p] == int'(cfg_max_groups)) close = 1'b1;
      end
      if (last) close = 1'b1;
      if (close) m_act[p] = 1'b0;
    end
    @(negedge clk);
    if (close) begin
      en = m_n[p] * m_sty[p] - m_st[p] * m_sy[p];
      eden = m_n[p] * m_stt[p] - m_st[p] * m_st[p];
      chk(out_valid === 1'b1, {tag, " R11 valid"}, out_valid, 1);
      chk(out_pix === PW'(p), {tag, " R6 pix"}, out_pix, p);
      chk(longint'(out_num) == en, {tag, " R5 num"}, longint'(out_num), en);
      chk(longint'(out_den) == eden, {tag, " R5 den"}, longint'(out_den), eden);
      chk(longint'(out_count) == m_n[p], {tag, " R5 count"}, longint'(out_count), m_n[p]);
      chk(out_invalid === (m_n[p] < 2), {tag, " R8 flag"}, out_invalid, m_n[p] < 2);
    end else begin
      chk(out_valid === 1'b0, {tag, " R11 quiet"}, out_valid, 0);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 idle quiet", out_valid, 0);
  endtask

  task automatic set_cfg(input int m, input int skip, input int mx);
    cfg_group_frames = FW'(m); cfg_skip_groups = CW'(skip); cfg_max_groups = CW'(mx);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R1 reset out_valid", out_valid, 0);
    set_cfg(1, 0, MG);
    feed(0, 100, 0, 1, "R1 idle spaxel");
    feed(0, 200, 0, 0, "R1 idle spaxel");
    idle();
  endtask

  task automatic t_linear();
    set_cfg(1, 0, MG);
    for (int k = 0; k < 5; k++) feed(2, 10 + 3 * k, k == 0, k == 4, "R5 linear");
    chk(out_num == 150, "R5 linear num", longint'(out_num), 150);
    chk(out_den == 50, "R5 linear den", longint'(out_den), 50);
    idle();
  endtask

  task automatic t_group_skip();
    set_cfg(3, 1, MG);
    for (int k = 0; k < 11; k++) feed(1, k * k + 7, k == 0, k == 10, "R3 R4 group skip");
    chk(out_count == 2, "R4 accepted count", longint'(out_count), 2);
    idle();
  endtask

  task automatic t_max_len();
    set_cfg(2, 0, 3);
    for (int k = 0; k < 6; k++) feed(5, 50 + 11 * k, k == 0, 1'b0, "R7 max close");
    feed(5, 999, 0, 1, "R7 ignored after close");
    feed(5, 20, 1, 0, "R7 reopen");
    feed(5, 40, 0, 1, "R7 reopen");
    idle();
  endtask

  task automatic t_degenerate();
    set_cfg(1, 0, MG);
    feed(3, 77, 1, 1, "R8 single");
    chk(out_den == 0 && out_invalid, "R8 single den", longint'(out_den), 0);
    set_cfg(1, 2, MG);
    for (int k = 0; k < 3; k++) feed(3, 5 * k, k == 0, k == 2, "R8 one kept");
    chk(out_count == 1, "R8 one kept count", longint'(out_count), 1);
    set_cfg(2, 0, MG);
    feed(3, 9, 1, 0, "R8 none kept");
    feed(3, 9, 0, 0, "R8 none kept");
    feed(3, 9, 0, 1, "R6 partial dropped");
    idle();
  endtask

  task automatic t_interleave();
    set_cfg(1, 0, MG);
    for (int k = 0; k < 6; k++) begin
      feed(6, 1000 - 40 * k, k == 0, k == 5, "R9 spaxel6");
      feed(7, 3 * k * k, k == 0, k == 5, "R9 spaxel7");
    end
    idle();
  endtask

  task automatic t_restart();
    set_cfg(1, 0, MG);
    feed(4, 3000, 1, 0, "R2 old ramp");
    feed(4, 3500, 0, 0, "R2 old ramp");
    for (int k = 0; k < 3; k++) feed(4, 2 * k, k == 0, k == 2, "R2 new ramp");
    chk(out_num == 12 && out_count == 3, "R2 restart num", longint'(out_num), 12);
    idle();
  endtask

  task automatic t_full_scale();
    set_cfg(MF, 0, MG);
    for (int k = 0; k < MF * MG; k++) feed(0, (1 << SW) - 1, k == 0, 1'b0, "R10 full scale");
    chk(out_count == MG, "R10 count", longint'(out_count), MG);
    chk(out_den == 87296, "R10 den", longint'(out_den), 87296);
    chk(out_num == 0, "R10 num", longint'(out_num), 0);
    idle();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    in_pix = '0; in_sample = '0;
    set_cfg(1, 0, MG);
    for (int i = 0; i < NPIX; i++) m_act[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_linear();
    t_group_skip();
    t_max_len();
    t_degenerate();
    t_interleave();
    t_restart();
    t_full_scale();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule